// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block guards a system against software that has stopped running properly. A slow reference clock drives a fixed prescaler, and the prescaler drives an up-counter. Software programs a reference value and then sets an enable bit. After that the watchdog can no longer be switched off by software. Software must write the counter register often enough that the counter never reaches the reference value. If it does reach it, the block does one of two things, chosen by a force-interrupt bit:

- It pulses a system reset request and stops itself.
- It raises a maskable interrupt and keeps counting.

Three registers make up the programming interface: control/status, reference and counter. Register writes take effect at the next clock edge. Reads are combinational and free of side effects. A reset-status flag records that the watchdog caused a reset. The flag survives that reset, so boot code can find out why the system restarted. The chip-level synchronous software reset input clears the running state but keeps that flag.

Top module: `wdog_timer`

## Requirements
- R1: After the external reset `rst_n` has been released, the following hold:
  - the control/status register (address 0) reads 0;
  - the reference register (address 1) reads all ones;
  - the counter (address 2) reads 0;
  - `rst_req` and `irq` are low.
- R2: While the enable bit (bit 0 at address 0) is clear, the counter stays at 0. Writing 1 to the enable bit starts counting from 0, with the prescaler phase also at 0.
- R3: While enabled, the counter advances by one every PRESCALE clocks. A read m cycles after a counter write returns floor(m/PRESCALE), modulo 2^CNT_W.
- R4: While the watchdog runs, a write of 0 to the enable bit is ignored. The force-interrupt bit (bit 1 at address 0) and the reference register stay writable.
- R5: The reset action applies when force-interrupt is 0 and the counter reaches the reference value. This happens exactly reference × PRESCALE cycles after the last counter write or enable. At that moment:
  - `rst_req` goes high for exactly one clock;
  - the counter clears to 0;
  - the enable bit clears.
- R6: The reset-status bit (bit 2 at address 0) behaves as follows:
  - a watchdog reset sets it;
  - it stays set until software writes 1 to it;
  - the external reset `rst_n` clears it.
- R7: The interrupt action applies when force-interrupt is 1 and the counter reaches the reference value. Then:
  - `irq` and the pending bit (bit 3 at address 0) go high;
  - no reset request is made;
  - the counter keeps counting.
- R8: Any write to the counter register clears the counter to 0, clears a pending interrupt and restarts the prescaler phase. The written data is ignored.
- R9: After an interrupt-mode match, the counter wraps from all ones to 0 and keeps counting. `irq` stays high until the next counter write.
- R10: A `sw_rst` pulse clears the enable bit, the counter and a pending interrupt. It leaves the reset-status bit unchanged.
- R11: Reading any register does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | External reset, asynchronous, active low |
| sw_rst | input | 1 | Synchronous software reset from the chip |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control/status, 1 reference, 2 counter |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the selected register |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Maskable watchdog interrupt, held until serviced |

## Verification
The bench builds the block with CNT_W = 8 and PRESCALE = 8. With these values the counter wraps from 255 to 0 after 2048 clocks. That puts the wrap under a pending interrupt within reach of a short run, which the 16-bit default would not allow. Random reference values and random prescaler phases before the service write test the exact reset interval. Random wait times test the counter reads against floor(m/8).

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_REF  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  localparam int BIT_EN    = 0;
  localparam int BIT_FI    = 1;
  localparam int BIT_RSTAT = 2;
  localparam int BIT_IRQ   = 3;

  typedef struct packed {
    logic irq_pend;
    logic rst_stat;
    logic force_irq;
    logic enable;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] ps_q, ps_d;

  assign tick = run && (ps_q == PS_LAST);

  always_comb begin
    ps_d = ps_q;
    if (clr)      ps_d = '0;
    else if (run) ps_d = tick ? '0 : ps_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);
  // match is taken on the tick that brings the count to the reference
  assign hit     = tick && (cnt_inc == ref_val);
  assign cnt     = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic [CNT_W-1:0] ref_val,
  output logic             cnt_clr,
  output logic             irq,
  output logic             rst_req,
  output logic [CNT_W-1:0] reg_rdata
);
  wd_ctrl_t         ctrl_q, ctrl_d;
  logic [CNT_W-1:0] ref_q, ref_d;
  logic             req_q, req_d;
  logic             wr_ctrl, wr_ref, wr_cnt, en_start, fire_rst, fire_irq;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_ref   = reg_wr && (reg_addr == ADDR_REF);
  assign wr_cnt   = reg_wr && (reg_addr == ADDR_CNT);
  assign en_start = wr_ctrl && reg_wdata[BIT_EN] && !ctrl_q.enable;

  // service write and software reset both take precedence over a match
  assign fire_rst = hit && ctrl_q.enable && !ctrl_q.force_irq && !wr_cnt && !sw_rst;
  assign fire_irq = hit && ctrl_q.enable &&  ctrl_q.force_irq && !wr_cnt && !sw_rst;

  always_comb begin
    ctrl_d = ctrl_q;
    ref_d  = ref_q;
    req_d  = fire_rst;

    if (sw_rst || fire_rst) ctrl_d.enable = 1'b0;
    else if (en_start)      ctrl_d.enable = 1'b1;

    if (wr_ctrl) ctrl_d.force_irq = reg_wdata[BIT_FI];

    if (fire_rst)                               ctrl_d.rst_stat = 1'b1;
    else if (wr_ctrl && reg_wdata[BIT_RSTAT])   ctrl_d.rst_stat = 1'b0;

    if (wr_cnt || sw_rst || fire_rst) ctrl_d.irq_pend = 1'b0;
    else if (fire_irq)                ctrl_d.irq_pend = 1'b1;

    if (wr_ref) ref_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '1;
      req_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ref_q  <= ref_d;
      req_q  <= req_d;
    end
  end

  assign run     = ctrl_q.enable;
  assign ref_val = ref_q;
  assign irq     = ctrl_q.irq_pend;
  assign rst_req = req_q;
  assign cnt_clr = wr_cnt || sw_rst || fire_rst || en_start;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata[3:0] = ctrl_q;
      ADDR_REF:  reg_rdata      = ref_q;
      ADDR_CNT:  reg_rdata      = cnt;
      default:   reg_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             rst_req,
  output logic             irq
);
  logic             rst_sync_n;
  logic             run_en, tick, cnt_clr, hit;
  logic [CNT_W-1:0] ref_val, cnt_val;

  wdog_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_prescaler #(.PRESCALE(PRESCALE)) u_ps (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run_en),
    .clr   (cnt_clr),
    .tick  (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .clr     (cnt_clr),
    .ref_val (ref_val),
    .cnt     (cnt_val),
    .hit     (hit)
  );

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sw_rst    (sw_rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .cnt       (cnt_val),
    .run       (run_en),
    .ref_val   (ref_val),
    .cnt_clr   (cnt_clr),
    .irq       (irq),
    .rst_req   (rst_req),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             rst_req,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             en
);
  // R5
  rst_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5
  rst_stops_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0) && !en);

  // R4
  en_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> ($past(sw_rst) || rst_req));

  // R8
  service_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (cnt == '0) && !irq);

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !en && (cnt == '0) && !irq);

  // R7
  irq_not_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !rst_req);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> ((cnt == $past(cnt)) || (cnt == '0)));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .sw_rst   (sw_rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .rst_req  (rst_req),
  .irq      (irq),
  .cnt      (cnt_val),
  .en       (run_en)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int CNT_W      = 8;
  localparam int PS         = 8;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n, sw_rst, reg_wr;
  logic [1:0]       reg_addr;
  logic [CNT_W-1:0] reg_wdata, reg_rdata;
  logic             rst_req, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.CNT_W(CNT_W), .PRESCALE(PS)) uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_req(rst_req), .irq(irq)
  );

  function automatic logic [CNT_W-1:0] exp_cnt(input int m);
    return CNT_W'(m / PS);
  endfunction

  function automatic int exp_interval(input int refv);
    return refv * PS;
  endfunction

  function automatic logic [CNT_W-1:0] ctrl_val(input bit en, input bit fi,
                                                input bit rs, input bit ip);
    logic [CNT_W-1:0] v;
    v = '0;
    v[0] = en; v[1] = fi; v[2] = rs; v[3] = ip;
    return v;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; sw_rst = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  // reset-mode run: enable, random phase, service, measure interval
  task automatic fire_run(input int refv, input int pre, input bit clear_stat);
    logic [CNT_W-1:0] d;
    int first, highs;
    wr(2'd1, CNT_W'(refv));
    wr(2'd0, ctrl_val(1, 0, 0, 0));
    idle(pre);
    wr(2'd2, '0);
    first = -1; highs = 0;
    for (int n = 1; n <= exp_interval(refv) + 2; n++) begin
      @(negedge clk);
      if (rst_req) begin
        highs++;
        if (first < 0) first = n;
      end
    end
    check("R5 interval", first, exp_interval(refv));
    check("R5 pulse width", highs, 1);
    rd(2'd0, d);
    check("R6 status set, R5 enable cleared", int'(d), int'(ctrl_val(0, 0, 1, 0)));
    rd(2'd2, d);
    check("R5 counter cleared", int'(d), 0);
    if (clear_stat) begin
      wr(2'd0, ctrl_val(0, 0, 1, 0));
      rd(2'd0, d);
      check("R6 write-one clears status", int'(d), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] d;
    int m, k, seed;
    seed = 1234;
    void'($urandom(seed));
    do_reset();

    // R1
    rd(2'd0, d); check("R1 ctrl reset", int'(d), 0);
    rd(2'd1, d); check("R1 ref reset", int'(d), (1 << CNT_W) - 1);
    rd(2'd2, d); check("R1 cnt reset", int'(d), 0);
    check("R1 rst_req low", int'(rst_req), 0);
    check("R1 irq low", int'(irq), 0);

    // R2: no counting while disabled
    idle(40);
    rd(2'd2, d); check("R2 idle counter", int'(d), 0);

    // R5 / R6 directed and random reference values and phases
    fire_run(2, 0, 1'b1);
    for (int it = 0; it < 6; it++)
      fire_run(2 + int'($urandom_range(0, 18)), int'($urandom_range(0, 7)), 1'b1);

    // R7: interrupt mode, counter keeps going
    wr(2'd1, CNT_W'(3));
    wr(2'd0, ctrl_val(1, 1, 0, 0));
    m = -1;
    for (int n = 1; n <= exp_interval(3); n++) begin
      @(negedge clk);
      if (irq && m < 0) m = n;
      if (rst_req) check("R7 no reset request", 1, 0);
    end
    check("R7 irq timing", m, exp_interval(3));
    idle(16);
    rd(2'd2, d); check("R7 counting continues", int'(d), 5);
    rd(2'd0, d); check("R7 pending bit", int'(d), int'(ctrl_val(1, 1, 0, 1)));

    // R8: service write with nonzero data
    wr(2'd2, CNT_W'(8'h55));
    check("R8 irq cleared", int'(irq), 0);
    rd(2'd2, d); check("R8 counter cleared", int'(d), 0);

    // R4: disable ignored, FI and ref writable
    wr(2'd0, ctrl_val(0, 0, 0, 0));
    rd(2'd0, d); check("R4 enable sticky, FI writable", int'(d), int'(ctrl_val(1, 0, 0, 0)));
    wr(2'd1, CNT_W'(200));
    rd(2'd1, d); check("R4 ref writable", int'(d), 200);

    // R3 / R11: random waits, repeated reads
    for (int it = 0; it < 8; it++) begin
      m = int'($urandom_range(0, 300));
      k = int'($urandom_range(1, 400));
      wr(2'd2, '0);
      idle(m);
      rd(2'd2, d); check("R3 count after wait", int'(d), int'(exp_cnt(m)));
      rd(2'd0, d);
      idle(k);
      rd(2'd2, d); check("R11 read does not disturb", int'(d), int'(exp_cnt(m + k)));
    end

    // R9: wrap after interrupt-mode match
    wr(2'd0, ctrl_val(1, 1, 0, 0));
    wr(2'd1, CNT_W'(2));
    wr(2'd2, '0);
    idle(PS * 257 + 3);
    rd(2'd2, d); check("R9 wrapped count", int'(d), int'(exp_cnt(PS * 257 + 3)));
    check("R9 irq held", int'(irq), 1);

    // R10: software reset keeps status
    wr(2'd0, ctrl_val(0, 0, 0, 0));
    wr(2'd2, '0);
    fire_run(4, 3, 1'b0);
    wr(2'd0, ctrl_val(1, 0, 0, 0));
    rd(2'd0, d); check("R6 status survives re-enable", int'(d), int'(ctrl_val(1, 0, 1, 0)));
    idle(20);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    rd(2'd0, d); check("R10 sw reset ctrl", int'(d), int'(ctrl_val(0, 0, 1, 0)));
    rd(2'd2, d); check("R10 sw reset counter", int'(d), 0);
    idle(30);
    rd(2'd2, d); check("R2 stays idle after sw reset", int'(d), 0);

    // R6: external reset clears status
    do_reset();
    rd(2'd0, d); check("R6 external reset clears status", int'(d), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule